// File: doc/BRIEF.md
# Register-Driven Serial Flash Command Sequencer

This block sends one flash command at a time on a serial flash bus with one, two or four data lines. Software programs a control word (opcode, optional phases and their lengths), an address word, a mode byte, a lane-width setting and up to eight bytes of outgoing data. It then writes the execute bit. The sequencer drives chip select and the serial clock, and walks the command phases in a fixed order: opcode, address, mode byte, dummy clocks, write data, read data. Every phase uses the lane width that is selected at launch.

Each serial clock period takes two system clocks: a low half and then a high half. Output data changes only on the edge that starts a low half. Input data is sampled on the edge that ends a high half. Received bytes go into a 64-bit read holding register. While the command runs, a status bit reads back as one. All register writes are refused during that time.

Top module: `flash_cmd_seq`

## Requirements
- R1: Register words on the bus are numbered as follows: 0 is control, 1 is address, 2 is mode (bits 7:0), 3 is lane width (bits 1:0), 4 and 5 are write data (low and high halves), 6 and 7 are read data (low and high halves). After reset, every word reads zero, chip select is high, the serial clock is low and no data line is driven.
- R2: Writing control with bit 0 set while idle starts a command. Control bit 1 reads one from the launch until one cycle after chip select returns high. Bit 0 and bits 6:2 always read zero. Bits 31:7 read back as written.
- R3: The opcode (control bits 31:24) is sent first, most significant bit first. Each serial clock is one low cycle followed by one high cycle, and output data changes only at the start of a low cycle.
- R4: When control bit 19 is set, an address phase follows the opcode. Its length is control bits 17:16 plus one byte, taken from the low bytes of the address word and sent most significant byte first.
- R5: When control bit 18 is set, bits 7:0 of the mode word are sent right after the address phase.
- R6: Control bits 11:7 give 0 to 31 dummy clocks. These come after the address and mode phases and before any data, with all data lines released. A value of 0 adds no dummy clocks.
- R7: When control bit 15 is set, control bits 14:12 plus one write-data bytes are sent. Byte 0 is bits 7:0 of word 4, and bytes go out in ascending order. This phase comes before any read phase.
- R8: When control bit 23 is set, control bits 22:20 plus one bytes are received with all lines released. Received byte k goes to bits 8k+7:8k of the 64-bit read register. Bytes that are not received read as zero.
- R9: Lane code 00 or 11 selects single-line mode: output on DQ0, input on DQ1. Code 01 selects two lines and code 10 selects four lines. Each clock then carries 2 or 4 bits, and the highest-numbered line carries the most significant bit of each group.
- R10: While a command is running, bus writes to any word are ignored. This includes a second execute write.
- R11: Chip select goes low in the cycle after launch and rises in the cycle after the last high half. The serial clock stays low and no line is driven while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word select |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Registered read data for the word selected in the previous cycle |
| flash_cs_n | output | 1 | Active-low chip select |
| flash_sclk | output | 1 | Serial clock |
| flash_dq_out | output | 4 | Data line output values |
| flash_dq_oe | output | 4 | Per-line output enables |
| flash_dq_in | input | 4 | Data line input values |

## Verification
The assertions assume that software reprograms nothing during a command, and the block itself enforces this by refusing writes while busy. They also assume the flash presents read bits so that they are steady across the edge that ends each high half. The bench drives its data-line input only at falling system-clock edges, from the same per-cycle model it uses to predict the pins. Every sampled bit is therefore settled a half cycle before the design captures it. The bench programs registers only while idle, except in the one scenario that deliberately writes during a busy command to exercise the ignore rule.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_OPC   = 3'd1,
    PH_ADDR  = 3'd2,
    PH_MODE  = 3'd3,
    PH_DUMMY = 3'd4,
    PH_WDATA = 3'd5,
    PH_RDATA = 3'd6,
    PH_DONE  = 3'd7
  } phase_e;

  // Field order follows control bits 31:7, top field first.
  typedef struct packed {
    logic [7:0] opcode;
    logic       rd_en;
    logic [2:0] rd_cnt;
    logic       addr_en;
    logic       mode_en;
    logic [1:0] addr_len;
    logic       wr_en;
    logic [2:0] wr_cnt;
    logic [4:0] dummy;
  } cmd_cfg_t;

  localparam int CFG_W = $bits(cmd_cfg_t);

  localparam logic [2:0] REG_CTRL = 3'd0;
  localparam logic [2:0] REG_ADDR = 3'd1;
  localparam logic [2:0] REG_MODE = 3'd2;
  localparam logic [2:0] REG_LANE = 3'd3;
  localparam logic [2:0] REG_WLO  = 3'd4;
  localparam logic [2:0] REG_WHI  = 3'd5;
  localparam logic [2:0] REG_RLO  = 3'd6;
  localparam logic [2:0] REG_RHI  = 3'd7;

  localparam logic [1:0] LANE_DUAL = 2'b01;
  localparam logic [1:0] LANE_QUAD = 2'b10;

endpackage

// File: rtl/flash_lane_map.sv
module flash_lane_map
  import flash_cmd_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic [1:0]       lane_code,
  input  logic [LANES-1:0] dq_in,
  output logic [2:0]       bits_per_beat,
  output logic [3:0]       beats_per_byte,
  output logic [LANES-1:0] oe_mask,
  output logic [LANES-1:0] in_bits
);

  always_comb begin
    case (lane_code)
      LANE_DUAL: begin
        bits_per_beat  = 3'd2;
        beats_per_byte = 4'd4;
        oe_mask        = LANES'(4'b0011);
        in_bits        = LANES'({2'b00, dq_in[1:0]});
      end
      LANE_QUAD: begin
        bits_per_beat  = 3'd4;
        beats_per_byte = 4'd2;
        oe_mask        = LANES'(4'b1111);
        in_bits        = dq_in;
      end
      default: begin
        // R9: single line, out on DQ0, in on DQ1
        bits_per_beat  = 3'd1;
        beats_per_byte = 4'd8;
        oe_mask        = LANES'(4'b0001);
        in_bits        = LANES'({3'b000, dq_in[1]});
      end
    endcase
  end

endmodule

// File: rtl/flash_cmd_regs.sv
module flash_cmd_regs
  import flash_cmd_pkg::*;
#(
  parameter int AW = 3,
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_we,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic            busy,
  input  logic            rd_load,
  input  logic [2*DW-1:0] rd_word,
  output logic            launch,
  output cmd_cfg_t        launch_cfg,
  output logic [DW-1:0]   flash_addr,
  output logic [7:0]      mode_byte,
  output logic [1:0]      lane_code,
  output logic [2*DW-1:0] wr_word
);

  localparam int LOW_W = DW - CFG_W;

  cmd_cfg_t        cfg_q;
  logic [DW-1:0]   addr_q;
  logic [7:0]      mode_q;
  logic [1:0]      lane_q;
  logic [2*DW-1:0] wr_q;
  logic [2*DW-1:0] rd_q;
  logic            wr_ok;

  assign wr_ok      = bus_we && !busy;
  assign launch     = wr_ok && (bus_addr == REG_CTRL) && bus_wdata[0];
  assign launch_cfg = cmd_cfg_t'(bus_wdata[DW-1:LOW_W]);
  assign flash_addr = addr_q;
  assign mode_byte  = mode_q;
  assign lane_code  = lane_q;
  assign wr_word    = wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      addr_q <= '0;
      mode_q <= '0;
      lane_q <= '0;
      wr_q   <= '0;
      rd_q   <= '0;
    end else begin
      if (wr_ok) begin
        case (bus_addr)
          REG_CTRL: cfg_q  <= launch_cfg;
          REG_ADDR: addr_q <= bus_wdata;
          REG_MODE: mode_q <= bus_wdata[7:0];
          REG_LANE: lane_q <= bus_wdata[1:0];
          REG_WLO:  wr_q[DW-1:0]    <= bus_wdata;
          REG_WHI:  wr_q[2*DW-1:DW] <= bus_wdata;
          default: ;
        endcase
      end
      if (rd_load) rd_q <= rd_word;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      case (bus_addr)
        REG_CTRL: bus_rdata <= {cfg_q, (LOW_W-2)'(0), busy, 1'b0};
        REG_ADDR: bus_rdata <= addr_q;
        REG_MODE: bus_rdata <= DW'(mode_q);
        REG_LANE: bus_rdata <= DW'(lane_q);
        REG_WLO:  bus_rdata <= wr_q[DW-1:0];
        REG_WHI:  bus_rdata <= wr_q[2*DW-1:DW];
        REG_RLO:  bus_rdata <= rd_q[DW-1:0];
        default:  bus_rdata <= rd_q[2*DW-1:DW];
      endcase
    end
  end

  // R10: a busy-time write leaves the address word alone
  a_r10_addr_frozen: assert property (@(posedge clk) disable iff (rst)
    (busy && bus_we && bus_addr == REG_ADDR) |=> $stable(addr_q));

  // R10: a busy-time write leaves the control word alone
  a_r10_ctrl_frozen: assert property (@(posedge clk) disable iff (rst)
    (busy && bus_we && bus_addr == REG_CTRL) |=> $stable(cfg_q));

endmodule

// File: rtl/flash_cmd_engine.sv
module flash_cmd_engine
  import flash_cmd_pkg::*;
#(
  parameter int SH_W  = 64,
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             launch,
  input  cmd_cfg_t         launch_cfg,
  input  logic [31:0]      flash_addr,
  input  logic [7:0]       mode_byte,
  input  logic [1:0]       lane_code,
  input  logic [SH_W-1:0]  wr_word,
  input  logic [LANES-1:0] dq_in,
  output logic             cs_n,
  output logic             sclk,
  output logic [LANES-1:0] dq_out,
  output logic [LANES-1:0] dq_oe,
  output logic             busy,
  output logic             rd_load,
  output logic [SH_W-1:0]  rd_word
);

  localparam int NB    = SH_W / 8;
  localparam int CNT_W = $clog2(SH_W + 1);

  phase_e           ph_q, nxt_ph, ld_ph;
  cmd_cfg_t         cfg_q, cfg_use;
  logic [1:0]       lanes_q, lanes_use;
  logic             half_q;
  logic [CNT_W-1:0] cnt_q, ld_cnt;
  logic [SH_W-1:0]  tx_q, ld_tx, tx_shift;
  logic [SH_W-1:0]  rx_q, rx_fin, rd_pack;
  logic             ld_drive;
  logic [3:0]       nbytes;
  logic [4:0]       addr_sh;
  logic [7:0]       ph_en;
  logic [2:0]       bpb;
  logic [3:0]       beats_byte;
  logic [LANES-1:0] oe_mask, in_bits;

  assign lanes_use = launch ? lane_code : lanes_q;
  assign cfg_use   = launch ? launch_cfg : cfg_q;
  assign ld_ph     = launch ? PH_OPC : nxt_ph;

  flash_lane_map #(.LANES(LANES)) u_map (
    .lane_code      (lanes_use),
    .dq_in          (dq_in),
    .bits_per_beat  (bpb),
    .beats_per_byte (beats_byte),
    .oe_mask        (oe_mask),
    .in_bits        (in_bits)
  );

  function automatic logic [LANES-1:0] lane_out(input logic [SH_W-1:0] t,
                                                input logic [2:0] n);
    return LANES'(t[SH_W-1 -: 4] >> (3'd4 - n));
  endfunction

  // Which optional phases this command carries, in bus order.
  always_comb begin
    ph_en           = '0;
    ph_en[PH_ADDR]  = cfg_q.addr_en;
    ph_en[PH_MODE]  = cfg_q.mode_en;
    ph_en[PH_DUMMY] = (cfg_q.dummy != '0);
    ph_en[PH_WDATA] = cfg_q.wr_en;
    ph_en[PH_RDATA] = cfg_q.rd_en;
    nxt_ph = PH_DONE;
    for (int i = 6; i >= 2; i--) begin
      if (i > int'(ph_q) && ph_en[i]) nxt_ph = phase_e'(3'(i));
    end
  end

  // Shift register image and beat count for the phase being entered.
  always_comb begin
    ld_tx    = '0;
    ld_drive = 1'b0;
    nbytes   = 4'd0;
    addr_sh  = {2'd3 - cfg_use.addr_len, 3'b000};
    case (ld_ph)
      PH_OPC: begin
        ld_tx[SH_W-1 -: 8] = cfg_use.opcode;
        nbytes = 4'd1;  ld_drive = 1'b1;
      end
      PH_ADDR: begin
        ld_tx[SH_W-1 -: 32] = flash_addr << addr_sh;
        nbytes = {2'b00, cfg_use.addr_len} + 4'd1;  ld_drive = 1'b1;
      end
      PH_MODE: begin
        ld_tx[SH_W-1 -: 8] = mode_byte;
        nbytes = 4'd1;  ld_drive = 1'b1;
      end
      PH_WDATA: begin
        for (int i = 0; i < NB; i++) ld_tx[SH_W-1-8*i -: 8] = wr_word[8*i +: 8];
        nbytes = {1'b0, cfg_use.wr_cnt} + 4'd1;  ld_drive = 1'b1;
      end
      PH_RDATA: nbytes = {1'b0, cfg_use.rd_cnt} + 4'd1;
      default: ;
    endcase
    if (ld_ph == PH_DUMMY) ld_cnt = CNT_W'(cfg_use.dummy) - 1'b1;
    else ld_cnt = CNT_W'(nbytes) * CNT_W'(beats_byte) - 1'b1;
  end

  assign tx_shift = tx_q << bpb;
  assign rx_fin   = (rx_q << bpb) | SH_W'(in_bits);

  // R8: first received byte lands in byte 0
  always_comb begin
    rd_pack = '0;
    for (int i = 0; i < NB; i++) begin
      if (i <= int'(cfg_q.rd_cnt))
        rd_pack[8*i +: 8] = rx_fin[8*(int'(cfg_q.rd_cnt) - i) +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q    <= PH_IDLE;
      cfg_q   <= '0;
      lanes_q <= '0;
      half_q  <= 1'b0;
      cnt_q   <= '0;
      tx_q    <= '0;
      rx_q    <= '0;
      cs_n    <= 1'b1;
      sclk    <= 1'b0;
      dq_out  <= '0;
      dq_oe   <= '0;
      busy    <= 1'b0;
      rd_load <= 1'b0;
      rd_word <= '0;
    end else begin
      rd_load <= 1'b0;
      if (launch) begin
        cfg_q   <= launch_cfg;
        lanes_q <= lane_code;
        ph_q    <= PH_OPC;
        half_q  <= 1'b0;
        cnt_q   <= ld_cnt;
        tx_q    <= ld_tx;
        rx_q    <= '0;
        cs_n    <= 1'b0;
        sclk    <= 1'b0;
        dq_out  <= lane_out(ld_tx, bpb);
        dq_oe   <= oe_mask;
        busy    <= 1'b1;
      end else begin
        case (ph_q)
          PH_IDLE: ;
          PH_DONE: begin
            busy <= 1'b0;
            ph_q <= PH_IDLE;
          end
          default: begin
            if (!half_q) begin
              sclk   <= 1'b1;
              half_q <= 1'b1;
            end else begin
              sclk   <= 1'b0;
              half_q <= 1'b0;
              if (ph_q == PH_RDATA) rx_q <= rx_fin;
              if (cnt_q == '0) begin
                if (ph_q == PH_RDATA) begin
                  rd_load <= 1'b1;
                  rd_word <= rd_pack;
                end
                if (nxt_ph == PH_DONE) begin
                  ph_q   <= PH_DONE;
                  cs_n   <= 1'b1;
                  dq_oe  <= '0;
                  dq_out <= '0;
                end else begin
                  ph_q   <= nxt_ph;
                  cnt_q  <= ld_cnt;
                  tx_q   <= ld_tx;
                  dq_out <= lane_out(ld_tx, bpb);
                  dq_oe  <= ld_drive ? oe_mask : '0;
                end
              end else begin
                cnt_q  <= cnt_q - 1'b1;
                tx_q   <= tx_shift;
                dq_out <= lane_out(tx_shift, bpb);
              end
            end
          end
        endcase
      end
    end
  end

  // R11: nothing driven and no clock while deselected
  a_r11_released_when_idle: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> (dq_oe == '0 && !sclk));

  // R3: data only moves on the edge that starts a low half
  a_r3_stable_on_high: assert property (@(posedge clk) disable iff (rst)
    sclk |-> ($stable(dq_out) && $stable(dq_oe)));

  // R2: status covers the whole selected window
  a_r2_busy_covers_cs: assert property (@(posedge clk) disable iff (rst)
    !cs_n |-> busy);

  // R2: status drops only after chip select has been high a cycle
  a_r2_busy_tail: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (cs_n && $past(cs_n)));

  // R9: enabled lanes are always a legal width
  a_r9_lane_mask: assert property (@(posedge clk) disable iff (rst)
    (dq_oe == 4'h0 || dq_oe == 4'h1 || dq_oe == 4'h3 || dq_oe == 4'hF));

  // R10: no launch lands on a running command
  a_r10_no_relaunch: assert property (@(posedge clk) disable iff (rst)
    busy |-> !launch);

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int BUS_AW = 3,
  parameter int BUS_DW = 32,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic [BUS_DW-1:0] bus_rdata,
  output logic              flash_cs_n,
  output logic              flash_sclk,
  output logic [LANES-1:0]  flash_dq_out,
  output logic [LANES-1:0]  flash_dq_oe,
  input  logic [LANES-1:0]  flash_dq_in
);

  localparam int SH_W = 2 * BUS_DW;

  logic              busy, rd_load, launch;
  logic [SH_W-1:0]   rd_word, wr_word;
  cmd_cfg_t          launch_cfg;
  logic [BUS_DW-1:0] flash_addr;
  logic [7:0]        mode_byte;
  logic [1:0]        lane_code;

  flash_cmd_regs #(.AW(BUS_AW), .DW(BUS_DW)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .busy       (busy),
    .rd_load    (rd_load),
    .rd_word    (rd_word),
    .launch     (launch),
    .launch_cfg (launch_cfg),
    .flash_addr (flash_addr),
    .mode_byte  (mode_byte),
    .lane_code  (lane_code),
    .wr_word    (wr_word)
  );

  flash_cmd_engine #(.SH_W(SH_W), .LANES(LANES)) u_engine (
    .clk        (clk),
    .rst        (rst),
    .launch     (launch),
    .launch_cfg (launch_cfg),
    .flash_addr (flash_addr),
    .mode_byte  (mode_byte),
    .lane_code  (lane_code),
    .wr_word    (wr_word),
    .dq_in      (flash_dq_in),
    .cs_n       (flash_cs_n),
    .sclk       (flash_sclk),
    .dq_out     (flash_dq_out),
    .dq_oe      (flash_dq_oe),
    .busy       (busy),
    .rd_load    (rd_load),
    .rd_word    (rd_word)
  );

endmodule

// File: tb/flash_cmd_seq_tb.sv
module flash_cmd_seq_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        flash_cs_n, flash_sclk;
  logic [3:0]  flash_dq_out, flash_dq_oe;
  logic [3:0]  flash_dq_in = '0;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  flash_cmd_seq u_dut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .flash_cs_n(flash_cs_n), .flash_sclk(flash_sclk),
    .flash_dq_out(flash_dq_out), .flash_dq_oe(flash_dq_oe),
    .flash_dq_in(flash_dq_in)
  );

  typedef struct {
    bit       cs_n;
    bit       sclk;
    bit [3:0] oe;
    bit [3:0] dout;
    bit [3:0] din;
    int       req;
  } exp_t;

  exp_t exp_q[$];

  // Programmed state as the bench believes it to be.
  bit [1:0]  g_lane;
  bit [31:0] g_addr;
  bit [7:0]  g_mode;
  bit [63:0] g_wdata;
  bit [7:0]  g_rb [8];

  // Per-cycle comparison of the flash pins against the queued model.
  always @(negedge clk) begin : cmp
    exp_t e;
    if (!rst) begin
      if (exp_q.size() > 0) e = exp_q.pop_front();
      else begin
        e.cs_n = 1; e.sclk = 0; e.oe = 0; e.dout = 0; e.din = 0; e.req = 11; // R11 idle
      end
      checks++;
      if (flash_cs_n !== e.cs_n || flash_sclk !== e.sclk || flash_dq_oe !== e.oe ||
          (flash_dq_out & e.oe) !== (e.dout & e.oe)) begin
        fails++;
        $display("FAIL R%0d pins cs_n=%b sclk=%b oe=%b dq=%b expected cs_n=%b sclk=%b oe=%b dq=%b",
                 e.req, flash_cs_n, flash_sclk, flash_dq_oe, flash_dq_out,
                 e.cs_n, e.sclk, e.oe, e.dout);
      end
      flash_dq_in <= e.din;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic int lanes_of(input bit [1:0] c);
    if (c == 2'b01) return 2;
    if (c == 2'b10) return 4;
    return 1;
  endfunction

  function automatic bit [3:0] grp(input bit [7:0] b, input int l, input int k);
    return 4'((b >> (8 - l*(k+1))) & ((1 << l) - 1));
  endfunction

  task automatic push_out(input bit [7:0] b, input int l, input int req);
    for (int k = 0; k < 8/l; k++) begin
      exp_t e;
      e.cs_n = 0; e.oe = 4'((1 << l) - 1); e.dout = grp(b, l, k); e.din = 0; e.req = req;
      e.sclk = 0; exp_q.push_back(e);
      e.sclk = 1; exp_q.push_back(e);
    end
  endtask

  task automatic push_in(input bit [7:0] b, input int l);
    for (int k = 0; k < 8/l; k++) begin
      exp_t e;
      e.cs_n = 0; e.oe = 0; e.dout = 0; e.req = 8;
      e.sclk = 0; e.din = 0; exp_q.push_back(e);
      e.sclk = 1; e.din = (l == 1) ? (grp(b, l, k) << 1) : grp(b, l, k);
      exp_q.push_back(e);
    end
  endtask

  task automatic build(input bit [31:0] c);
    int l;
    exp_t e;
    l = lanes_of(g_lane);                                   // R9 lane width
    push_out(c[31:24], l, 3);                               // R3 opcode first
    if (c[19])                                              // R4 address
      for (int i = int'(c[17:16]); i >= 0; i--) push_out(g_addr[8*i +: 8], l, 4);
    if (c[18]) push_out(g_mode, l, 5);                      // R5 mode byte
    for (int d = 0; d < int'(c[11:7]); d++) begin           // R6 dummy clocks
      e.cs_n = 0; e.oe = 0; e.dout = 0; e.din = 0; e.req = 6;
      e.sclk = 0; exp_q.push_back(e);
      e.sclk = 1; exp_q.push_back(e);
    end
    if (c[15])                                              // R7 write data
      for (int i = 0; i <= int'(c[14:12]); i++) push_out(g_wdata[8*i +: 8], l, 7);
    if (c[23])                                              // R8 read data
      for (int i = 0; i <= int'(c[22:20]); i++) push_in(g_rb[i], l);
    e.cs_n = 1; e.sclk = 0; e.oe = 0; e.dout = 0; e.din = 0; e.req = 11; // R11 release
    exp_q.push_back(e);
  endtask

  task automatic wr(input bit [2:0] a, input bit [31:0] d);
    @(negedge clk);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(input bit [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic setup(input bit [1:0] lane, input bit [31:0] addr, input bit [7:0] mode,
                       input bit [63:0] wdata);
    g_lane = lane; g_addr = addr; g_mode = mode; g_wdata = wdata;
    wr(3'd3, {30'd0, lane});
    wr(3'd1, addr);
    wr(3'd2, {24'd0, mode});
    wr(3'd4, wdata[31:0]);
    wr(3'd5, wdata[63:32]);
  endtask

  task automatic launch(input bit [31:0] c);
    @(negedge clk);
    bus_we = 1; bus_addr = 3'd0; bus_wdata = c | 32'd1;
    @(posedge clk);
    build(c);
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic wait_done;
    while (exp_q.size() != 0) @(posedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic check_rdata(input bit [31:0] c);
    logic [31:0] lo, hi;
    bit [63:0] expv = '0;
    for (int i = 0; i <= int'(c[22:20]); i++) expv[8*i +: 8] = g_rb[i];
    rd(3'd6, lo);
    rd(3'd7, hi);
    chk("R8 read data", {hi, lo}, expv);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    bit [31:0] c;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state of pins and registers
    chk("R1 cs_n", 64'(flash_cs_n), 64'd1);
    chk("R1 sclk", 64'(flash_sclk), 64'd0);
    chk("R1 oe", 64'(flash_dq_oe), 64'd0);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk("R1 register reset", 64'(v), 64'd0);
    end

    // Opcode only, single lane (R3)
    setup(2'b00, 32'h0, 8'h0, 64'h0);
    c = 32'h0600_0000;
    launch(c);
    wait_done();

    // Single lane, 3-byte address, 3-byte read (R4, R8, R2)
    setup(2'b00, 32'h0012_3456, 8'h00, 64'h0);
    g_rb = '{8'hA5, 8'h3C, 8'hF0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    c = {8'h03, 1'b1, 3'd2, 1'b1, 1'b0, 2'd2, 1'b0, 3'd0, 5'd0, 7'd0};
    launch(c);
    rd(3'd0, v);
    chk("R2 busy while running", 64'(v), 64'({c[31:7], 7'b0000010}));
    wait_done();
    rd(3'd0, v);
    chk("R2 status after finish", 64'(v), 64'({c[31:7], 7'b0}));
    check_rdata(c);

    // Quad: 4-byte address, mode, 6 dummy, 8-byte read (R5, R6, R9)
    setup(2'b10, 32'hC1D2_E3F4, 8'h5A, 64'h0);
    g_rb = '{8'h11, 8'h92, 8'h3B, 8'hC4, 8'h5D, 8'hE6, 8'h7F, 8'h08};
    c = {8'hEB, 1'b1, 3'd7, 1'b1, 1'b1, 2'd3, 1'b0, 3'd0, 5'd6, 7'd0};
    launch(c);
    wait_done();
    check_rdata(c);

    // Dual: 2-byte address, 4-byte write (R7, R9)
    setup(2'b01, 32'h0000_9ABC, 8'h00, 64'h0000_0000_8421_C3E7);
    c = {8'h32, 1'b0, 3'd0, 1'b1, 1'b0, 2'd1, 1'b1, 3'd3, 5'd0, 7'd0};
    launch(c);
    wait_done();
    rd(3'd4, v);
    chk("R7 write data kept", 64'(v), 64'h8421_C3E7);

    // Lane code 11 as single: 1-byte address, 31 dummy, write 2, read 1 (R6, R7, R8, R9)
    setup(2'b11, 32'h0000_007E, 8'h00, 64'h0000_0000_0000_B00F);
    g_rb = '{8'h69, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    c = {8'h5A, 1'b1, 3'd0, 1'b1, 1'b0, 2'd0, 1'b1, 3'd1, 5'd31, 7'd0};
    launch(c);
    wait_done();
    check_rdata(c);

    // Writes during a running command are ignored (R10)
    setup(2'b00, 32'h00AB_CDEF, 8'h00, 64'h0);
    g_rb = '{8'h77, 8'hE1, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    c = {8'h0B, 1'b1, 3'd1, 1'b1, 1'b0, 2'd2, 1'b0, 3'd0, 5'd8, 7'd0};
    launch(c);
    wr(3'd0, 32'hFF8F_FF81);
    wr(3'd1, 32'hDEAD_BEEF);
    wr(3'd3, 32'h0000_0002);
    wait_done();
    rd(3'd0, v);
    chk("R10 control unchanged", 64'(v), 64'({c[31:7], 7'b0}));
    rd(3'd1, v);
    chk("R10 address unchanged", 64'(v), 64'h00AB_CDEF);
    rd(3'd3, v);
    chk("R10 lane unchanged", 64'(v), 64'd0);
    check_rdata(c);

    repeat (4) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule